// File: doc/BRIEF.md
# Expansion Bus Autoconfiguration Slave

This block is the plug-and-play front end of an add-in card on a 16-bit asynchronous bus with a 24-bit byte address space. The bus carries word address bits 23:1, active-low address and byte-lane strobes, and a read/write line. Cards are configured one at a time along a daisy chain. While a card's chain input is low and the card is not yet configured, it answers reads in a 64 KB configuration window at byte address 0xE80000. Each read returns one identification nybble in the top four data bits. The host then writes the card's base address into fixed slots of the same window.

Writing the final base slot commits the configuration. From then on the card ignores the configuration window and pulls its chain output low, which lets the next card respond. It also raises a select whenever an access hits its own 64 KB window. A synchronous bus reset input returns the card to the unconfigured state. The bus data pins are modelled as a data output plus one output enable per byte lane, and the pad ring outside the block combines them.

Top module: `acfg_slave`

## Requirements
- R1: Out of reset the chain output `cfg_out_no` is high, both lane enables are low and `card_sel_o` is low.
- R2: The card drives data only while `as_ni` is low, `read_i` is high, `cfg_in_ni` is low, the card is unconfigured and the byte address lies in 0xE80000..0xE8FFFF. Lane enable bit 1 (bits 15:8) follows `uds_ni` low, and bit 0 (bits 7:0) follows `lds_ni` low.
- R3: A configuration read places a nybble in bits 15:12 and drives bits 11:0 as ones. Bytes 0x40 and above in the window read 0xFFFF.
- R4: Identification nybbles come from the parameters, high nybble first: board type at 0x00/0x02 (not inverted), product at 0x04/0x06, flags at 0x08/0x0A, manufacturer at 0x10..0x16 and serial at 0x18..0x26 (all inverted). Every other offset below 0x40 reads 0xF.
- R5: While `cfg_in_ni` is high, reads of the window are not driven and writes to it change nothing: the chain output stays high afterwards.
- R6: A write is accepted only with `uds_ni` low and takes data bits 15:8. Offset 0x48 loads the whole base page byte and offset 0x4A replaces its low nybble with bits 15:12. Offsets 0x44 and 0x46 do the same for an extension byte that holds address bits 31:24.
- R7: The writes to 0x44, 0x46 and 0x48 do not commit: the chain output stays high and identification reads still answer. The accepted write to 0x4A sets the card configured at that clock edge, and `cfg_out_no` goes low.
- R8: Once configured, the card no longer drives the configuration window.
- R9: `card_sel_o` is high exactly when `as_ni` is low, the card is configured, the extension byte is zero and address bits 23:16 equal the base page byte. Neighbouring pages give no select.
- R10: Holding `bus_rst_ni` low for one clock returns the card to unconfigured, with the chain output high and no select, and identification reads answer again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_rst_ni | input | 1 | Synchronous bus reset, active low |
| addr_i | input | 23 | Word address, bits 23:1 of the byte address |
| data_i | input | 16 | Write data from the bus |
| data_o | output | 16 | Read data toward the pads |
| data_oe_o | output | 2 | Lane enables: bit 1 for bits 15:8, bit 0 for bits 7:0 |
| as_ni | input | 1 | Address strobe, active low |
| uds_ni | input | 1 | Upper data strobe, active low |
| lds_ni | input | 1 | Lower data strobe, active low |
| read_i | input | 1 | High for a read cycle |
| cfg_in_ni | input | 1 | Daisy-chain enable in, active low |
| cfg_out_no | output | 1 | Daisy-chain enable out, active low |
| card_sel_o | output | 1 | Access hits the card's own 64 KB window |

## Verification
The bench splits the base byte across a full-byte write and a nybble write. A design that ignored the nybble slot or took it from the wrong bits would select page 0x9F instead of 0x91. It sends writes while the chain input is high, which a design that ignored the chain would commit. It also probes both the pages next to the assigned one, where a loose page compare would answer. It configures once with a nonzero extension byte, where the select must stay off, and checks reads with each single lane strobe. Bus reset is checked by reading identification data again after a full configuration.

// File: rtl/acfg_pkg.sv
package acfg_pkg;
  typedef enum logic {ST_UNCFG = 1'b0, ST_DONE = 1'b1} cfg_state_e;
  typedef enum logic [2:0] {
    SLOT_NONE, SLOT_EXT_HI, SLOT_EXT_LO, SLOT_BASE_HI, SLOT_BASE_LO
  } cfg_slot_e;
  localparam int NYB_W    = 4;
  localparam int ID_WORDS = 32;
  localparam int REG_W    = 8;
  // word indices of the base slots (byte offset / 2); slot order is behaviour
  localparam logic [5:0] WIX_EXT_HI  = 6'h22;
  localparam logic [5:0] WIX_EXT_LO  = 6'h23;
  localparam logic [5:0] WIX_BASE_HI = 6'h24;
  localparam logic [5:0] WIX_BASE_LO = 6'h25;
endpackage

// File: rtl/acfg_id_rom.sv
module acfg_id_rom
  import acfg_pkg::*;
#(
  parameter logic [7:0]  ID_TYPE    = 8'hC1,
  parameter logic [7:0]  ID_PRODUCT = 8'h23,
  parameter logic [7:0]  ID_FLAGS   = 8'h40,
  parameter logic [15:0] ID_MFR     = 16'h07DB,
  parameter logic [31:0] ID_SERIAL  = 32'h12345678
) (
  input  logic [$clog2(ID_WORDS)-1:0] idx_i,
  output logic [NYB_W-1:0]            nyb_o
);
  function automatic logic [NYB_W-1:0] raw_nyb(input int k);
    logic [NYB_W-1:0] r;
    r = '0;
    case (k)
      0: r = ID_TYPE[7:4];
      1: r = ID_TYPE[3:0];
      2: r = ID_PRODUCT[7:4];
      3: r = ID_PRODUCT[3:0];
      4: r = ID_FLAGS[7:4];
      5: r = ID_FLAGS[3:0];
      default: begin
        if (k >= 8 && k <= 11)       r = ID_MFR[15-4*(k-8) -: 4];
        else if (k >= 12 && k <= 19) r = ID_SERIAL[31-4*(k-12) -: 4];
      end
    endcase
    return r;
  endfunction

  function automatic bit is_def(input int k);
    return (k <= 5) || (k >= 8 && k <= 19);
  endfunction

  logic [NYB_W-1:0] tbl [ID_WORDS];

  for (genvar k = 0; k < ID_WORDS; k++) begin : g_tbl
    if (k < 2) begin : g_plain
      assign tbl[k] = raw_nyb(k);
    end else if (is_def(k)) begin : g_inv
      assign tbl[k] = ~raw_nyb(k);
    end else begin : g_rsv
      assign tbl[k] = '1;
    end
  end

  assign nyb_o = tbl[idx_i];
endmodule

// File: rtl/acfg_decode.sv
module acfg_decode
  import acfg_pkg::*;
#(
  parameter int          AW       = 24,
  parameter int          WIN_BITS = 16,
  parameter logic [23:0] CFG_BASE = 24'hE80000,
  localparam int         PAGE_W   = AW - WIN_BITS,
  localparam int         IDX_W    = $clog2(ID_WORDS)
) (
  input  logic [AW-1:1]     addr_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [REG_W-1:0]  ext_i,
  input  logic              done_i,
  output logic              cfg_hit_o,
  output logic              own_hit_o,
  output logic              id_area_o,
  output logic [IDX_W-1:0]  id_idx_o,
  output cfg_slot_e         slot_o
);
  logic [WIN_BITS-2:0] off;
  assign off = addr_i[WIN_BITS-1:1];

  assign cfg_hit_o = (addr_i[AW-1:WIN_BITS] == CFG_BASE[AW-1:WIN_BITS]);
  assign own_hit_o = done_i && (ext_i == '0) && (addr_i[AW-1:WIN_BITS] == page_i);
  assign id_area_o = (off[WIN_BITS-2:IDX_W] == '0);
  assign id_idx_o  = off[IDX_W-1:0];

  always_comb begin
    slot_o = SLOT_NONE;
    if (off[WIN_BITS-2:6] == '0) begin
      case (off[5:0])
        WIX_EXT_HI:  slot_o = SLOT_EXT_HI;
        WIX_EXT_LO:  slot_o = SLOT_EXT_LO;
        WIX_BASE_HI: slot_o = SLOT_BASE_HI;
        WIX_BASE_LO: slot_o = SLOT_BASE_LO;
        default:     slot_o = SLOT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/acfg_base_reg.sv
module acfg_base_reg
  import acfg_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_ni,
  input  logic              wr_i,
  input  cfg_slot_e         slot_i,
  input  logic [REG_W-1:0]  byte_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [REG_W-1:0]  ext_o,
  output logic              done_o
);
  logic [REG_W-1:0] base_q, ext_q;
  cfg_state_e       st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ext_q  <= '0;
      st_q   <= ST_UNCFG;
    end else if (!bus_rst_ni) begin
      base_q <= '0;
      ext_q  <= '0;
      st_q   <= ST_UNCFG;
    end else if (wr_i && st_q == ST_UNCFG) begin
      case (slot_i)
        SLOT_EXT_HI:  ext_q <= byte_i;
        SLOT_EXT_LO:  ext_q[3:0] <= byte_i[7:4];
        SLOT_BASE_HI: base_q <= byte_i;
        SLOT_BASE_LO: begin
          base_q[3:0] <= byte_i[7:4];
          st_q        <= ST_DONE;  // commit
        end
        default: ;
      endcase
    end
  end

  assign page_o = base_q[PAGE_W-1:0];
  assign ext_o  = ext_q;
  assign done_o = (st_q == ST_DONE);
endmodule

// File: rtl/acfg_slave.sv
module acfg_slave
  import acfg_pkg::*;
#(
  parameter int          AW         = 24,
  parameter int          WIN_BITS   = 16,
  parameter logic [23:0] CFG_BASE   = 24'hE80000,
  parameter logic [7:0]  ID_TYPE    = 8'hC1,
  parameter logic [7:0]  ID_PRODUCT = 8'h23,
  parameter logic [7:0]  ID_FLAGS   = 8'h40,
  parameter logic [15:0] ID_MFR     = 16'h07DB,
  parameter logic [31:0] ID_SERIAL  = 32'h12345678,
  localparam int         PAGE_W     = AW - WIN_BITS,
  localparam int         IDX_W      = $clog2(ID_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_rst_ni,
  input  logic [AW-1:1] addr_i,
  input  logic [15:0]   data_i,
  output logic [15:0]   data_o,
  output logic [1:0]    data_oe_o,
  input  logic          as_ni,
  input  logic          uds_ni,
  input  logic          lds_ni,
  input  logic          read_i,
  input  logic          cfg_in_ni,
  output logic          cfg_out_no,
  output logic          card_sel_o
);
  logic              cfg_hit, own_hit, id_area, done, cfg_live, rd_sel, wr;
  logic [IDX_W-1:0]  id_idx;
  logic [NYB_W-1:0]  nyb;
  logic [PAGE_W-1:0] page;
  logic [REG_W-1:0]  ext;
  cfg_slot_e         slot;

  acfg_decode #(.AW(AW), .WIN_BITS(WIN_BITS), .CFG_BASE(CFG_BASE)) u_dec (
    .addr_i(addr_i), .page_i(page), .ext_i(ext), .done_i(done),
    .cfg_hit_o(cfg_hit), .own_hit_o(own_hit), .id_area_o(id_area),
    .id_idx_o(id_idx), .slot_o(slot)
  );

  acfg_id_rom #(
    .ID_TYPE(ID_TYPE), .ID_PRODUCT(ID_PRODUCT), .ID_FLAGS(ID_FLAGS),
    .ID_MFR(ID_MFR), .ID_SERIAL(ID_SERIAL)
  ) u_rom (.idx_i(id_idx), .nyb_o(nyb));

  assign cfg_live = !cfg_in_ni && !done;
  assign rd_sel   = !as_ni && read_i && cfg_live && cfg_hit;
  assign wr       = !as_ni && !read_i && !uds_ni && cfg_live && cfg_hit;

  acfg_base_reg #(.PAGE_W(PAGE_W)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_rst_ni(bus_rst_ni),
    .wr_i(wr), .slot_i(slot), .byte_i(data_i[15:8]),
    .page_o(page), .ext_o(ext), .done_o(done)
  );

  assign data_oe_o  = {rd_sel && !uds_ni, rd_sel && !lds_ni};
  assign data_o     = id_area ? {nyb, 12'hFFF} : 16'hFFFF;
  assign cfg_out_no = !done;
  assign card_sel_o = !as_ni && own_hit;
endmodule

// File: rtl/acfg_slave_chk.sv
module acfg_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_rst_ni,
  input logic       as_ni,
  input logic       uds_ni,
  input logic       lds_ni,
  input logic       read_i,
  input logic       cfg_in_ni,
  input logic       cfg_out_no,
  input logic [1:0] data_oe_o,
  input logic       card_sel_o
);
  // R2
  oe_only_in_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o != 2'b00) |-> (!as_ni && read_i));
  // R2
  upper_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o[1] |-> !uds_ni);
  // R2
  lower_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o[0] |-> !lds_ni);
  // R5
  chain_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_in_ni |-> (data_oe_o == 2'b00));
  // R8
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_out_no |-> (data_oe_o == 2'b00));
  // R9
  sel_needs_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_sel_o |-> (!cfg_out_no && !as_ni));
  // R7
  commit_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_out_no) |-> $past(!as_ni && !read_i && !uds_ni && !cfg_in_ni));
  // R10
  bus_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rst_ni |=> cfg_out_no);
endmodule

bind acfg_slave acfg_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_rst_ni(bus_rst_ni), .as_ni(as_ni),
  .uds_ni(uds_ni), .lds_ni(lds_ni), .read_i(read_i), .cfg_in_ni(cfg_in_ni),
  .cfg_out_no(cfg_out_no), .data_oe_o(data_oe_o), .card_sel_o(card_sel_o)
);

// File: tb/sim_acfg_slave.sv
`timescale 1ns/1ps
module sim_acfg_slave;
  typedef struct {
    logic [1:0]  oe;
    logic [15:0] d;
    logic        sel;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_rst_ni = 1'b1;
  logic [23:1] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] data_o;
  logic [1:0]  data_oe;
  logic        as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rd = 1'b1;
  logic        cfg_in_n = 1'b1;
  logic        cfg_out_n, sel;

  int checks = 0, fails = 0;
  bit finished = 0;
  item_t exp_q[$];

  always #10 clk = ~clk;

  acfg_slave u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bus_rst_ni(bus_rst_ni), .addr_i(addr),
    .data_i(wdata), .data_o(data_o), .data_oe_o(data_oe), .as_ni(as_n),
    .uds_ni(uds_n), .lds_ni(lds_n), .read_i(rd), .cfg_in_ni(cfg_in_n),
    .cfg_out_no(cfg_out_n), .card_sel_o(sel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: one bus cycle, expectation queued for the monitor
  task automatic bus_cyc(input logic [23:0] a, input logic is_rd, input logic [15:0] d,
                         input logic u, input logic l, input logic [1:0] eoe,
                         input logic [15:0] ed, input logic esel, input string tag);
    item_t it;
    @(negedge clk);
    it.oe = eoe; it.d = ed; it.sel = esel; it.tag = tag;
    exp_q.push_back(it);
    addr = a[23:1]; rd = is_rd; wdata = d;
    as_n = 1'b0; uds_n = u; lds_n = l;
    @(negedge clk);
    as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1; rd = 1'b1;
  endtask

  task automatic id_rd(input logic [23:0] a, input logic [3:0] nyb, input string tag);
    bus_cyc(a, 1'b1, 16'h0, 1'b0, 1'b0, 2'b11, {nyb, 12'hFFF}, 1'b0, tag);
  endtask

  task automatic cfg_wr(input logic [23:0] a, input logic [15:0] d, input string tag);
    bus_cyc(a, 1'b0, d, 1'b0, 1'b0, 2'b00, 16'h0, 1'b0, tag);
  endtask

  // monitor: mid high phase, compare against queue head
  initial forever begin
    @(posedge clk);
    #5;
    if (!as_n) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected cycle actual=%0h expected=none", data_oe);
      end else begin
        item_t it;
        logic [15:0] m;
        it = exp_q.pop_front();
        m = {{8{it.oe[1]}}, {8{it.oe[0]}}};
        chk({it.tag, " lanes"}, {30'd0, data_oe}, {30'd0, it.oe});
        chk({it.tag, " data"}, {16'd0, data_o & m}, {16'd0, it.d & m});
        chk({it.tag, " sel"}, {31'd0, sel}, {31'd0, it.sel});
      end
    end
  end

  task automatic do_bus_rst();
    @(negedge clk); bus_rst_ni = 1'b0;
    @(negedge clk); bus_rst_ni = 1'b1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #3;
    // R1 reset state
    chk("R1 cfg_out", {31'd0, cfg_out_n}, 32'd1);
    chk("R1 oe", {30'd0, data_oe}, 32'd0);
    chk("R1 sel", {31'd0, sel}, 32'd0);

    // R5 chain high: reads silent, writes ignored
    bus_cyc(24'hE80000, 1'b1, 16'h0, 1'b0, 1'b0, 2'b00, 16'h0, 1'b0, "R5 read chain off");
    cfg_wr(24'hE80048, 16'h9100, "R5 wr hi chain off");
    cfg_wr(24'hE8004A, 16'h1000, "R5 wr lo chain off");
    chk("R5 cfg_out after ignored writes", {31'd0, cfg_out_n}, 32'd1);

    cfg_in_n = 1'b0;
    // R3 R4 identification
    id_rd(24'hE80000, 4'hC, "R4 type hi");
    id_rd(24'hE80002, 4'h1, "R4 type lo");
    id_rd(24'hE80004, 4'hD, "R4 product hi inv");
    id_rd(24'hE80006, 4'hC, "R4 product lo inv");
    id_rd(24'hE80008, 4'hB, "R4 flags hi inv");
    id_rd(24'hE80012, 4'h8, "R4 mfr inv");
    id_rd(24'hE80018, 4'hE, "R4 serial first inv");
    id_rd(24'hE80026, 4'h7, "R4 serial last inv");
    id_rd(24'hE8000C, 4'hF, "R4 reserved");
    id_rd(24'hE80028, 4'hF, "R4 reserved after serial");
    id_rd(24'hE80040, 4'hF, "R3 above id area");
    // R2 lanes
    bus_cyc(24'hE80000, 1'b1, 16'h0, 1'b0, 1'b1, 2'b10, 16'hCFFF, 1'b0, "R2 upper only");
    bus_cyc(24'hE80000, 1'b1, 16'h0, 1'b1, 1'b0, 2'b01, 16'hCFFF, 1'b0, "R2 lower only");
    bus_cyc(24'h100000, 1'b1, 16'h0, 1'b0, 1'b0, 2'b00, 16'h0, 1'b0, "R2 outside window");

    // R6 R7 staged base writes
    cfg_wr(24'hE80044, 16'h0000, "R6 ext hi");
    cfg_wr(24'hE80046, 16'h0000, "R6 ext lo");
    cfg_wr(24'hE80048, 16'h9F00, "R6 base hi");
    chk("R7 no commit before final slot", {31'd0, cfg_out_n}, 32'd1);
    id_rd(24'hE80002, 4'h1, "R7 still answering");
    cfg_wr(24'hE8004A, 16'h1000, "R6 base lo nybble");
    chk("R7 commit", {31'd0, cfg_out_n}, 32'd0);
    // R8
    bus_cyc(24'hE80000, 1'b1, 16'h0, 1'b0, 1'b0, 2'b00, 16'h0, 1'b0, "R8 window silent");
    // R9 decode
    bus_cyc(24'h910000, 1'b1, 16'h0, 1'b0, 1'b0, 2'b00, 16'h0, 1'b1, "R9 own page");
    bus_cyc(24'h91FFFE, 1'b0, 16'hBBBB, 1'b0, 1'b0, 2'b00, 16'h0, 1'b1, "R9 own page top");
    bus_cyc(24'h920000, 1'b1, 16'h0, 1'b0, 1'b0, 2'b00, 16'h0, 1'b0, "R9 next page");
    bus_cyc(24'h900000, 1'b1, 16'h0, 1'b0, 1'b0, 2'b00, 16'h0, 1'b0, "R9 prev page");
    bus_cyc(24'h800000, 1'b0, 16'hAAAA, 1'b0, 1'b0, 2'b00, 16'h0, 1'b0, "R9 other card");
    @(negedge clk); addr = 23'h910000 >> 1; #3;
    chk("R9 no select without strobe", {31'd0, sel}, 32'd0);

    // R10 bus reset
    do_bus_rst();
    #3;
    chk("R10 cfg_out", {31'd0, cfg_out_n}, 32'd1);
    bus_cyc(24'h910000, 1'b1, 16'h0, 1'b1, 1'b1, 2'b00, 16'h0, 1'b0, "R10 sel cleared");
    id_rd(24'hE80004, 4'hD, "R10 id again");

    // R9 nonzero extension byte: configured but unreachable
    cfg_wr(24'hE80044, 16'h0100, "R6 ext nonzero");
    cfg_wr(24'hE80048, 16'h9100, "R6 base hi");
    cfg_wr(24'hE8004A, 16'h1000, "R6 base lo");
    chk("R7 commit with ext", {31'd0, cfg_out_n}, 32'd0);
    bus_cyc(24'h910000, 1'b1, 16'h0, 1'b1, 1'b1, 2'b00, 16'h0, 1'b0, "R9 ext nonzero");

    // R6 write with upper strobe high is not accepted
    do_bus_rst();
    bus_cyc(24'hE8004A, 1'b0, 16'h1000, 1'b1, 1'b0, 2'b00, 16'h0, 1'b0, "R6 lds-only write");
    chk("R6 lds-only write ignored", {31'd0, cfg_out_n}, 32'd1);
    cfg_wr(24'hE80048, 16'h5500, "R6 base hi 55");
    cfg_wr(24'hE8004A, 16'h5000, "R6 base lo 5");
    bus_cyc(24'h550000, 1'b1, 16'h0, 1'b1, 1'b1, 2'b00, 16'h0, 1'b1, "R9 page 55");
    bus_cyc(24'h560000, 1'b1, 16'h0, 1'b1, 1'b1, 2'b00, 16'h0, 1'b0, "R9 page 56");

    repeat (3) @(negedge clk);
    chk("R2 queue drained", exp_q.size(), 32'd0);
    summary();
  end
endmodule